// File: doc/BRIEF.md
# Modular Exponentiation Engine

This block raises a message to an exponent modulo an odd modulus, Z = A^E mod M. The operand length is chosen at run time as a count of memory words. Every multiplication is done in the Montgomery domain by one bit-serial multiplier that the block reuses. A host prepares a job through one synchronous memory-style port with an address bus, a write-data bus, a read-data bus and a single write line. It writes the message, the exponent, the modulus and the constant R² mod M, where R = 2^(length·WORD_W). It writes the operand length and the number of exponent bits to scan. It then pulses `start`, polls the status word, and reads the result words back through the same port.

The constant R² mod M, the keys and the primes all come from host software. The word width is a synthesis parameter of 16, 32 or 64 bits. The largest operand, MAX_WORDS words, is also fixed at synthesis, but any length from one word up to that maximum can be chosen per job.

Top module: `mxp_engine`

## Requirements
- R1: With length L words, an odd M below 2^(L·WORD_W), A < M and the constant word region holding 2^(2·L·WORD_W) mod M, the result region holds A^E mod M once the job completes.
- R2: The exponent is scanned from bit (ebits−1) down to bit 0. Exponent bits at or above ebits have no effect on the result.
- R3: A job whose scanned exponent bits are all zero, including ebits = 0, returns 1 mod M: that is 1, or 0 when M = 1.
- R4: Address bits [ADDR_W−1 -: 3] select a region and the low log2(MAX_WORDS) bits select a word, with word 0 least significant. The regions are: 0 message, 1 exponent, 2 modulus, 3 Montgomery constant, 4 result (read-only), 5 configuration (word 0 length, word 1 ebits), 6 status. Read data appears one clock after the address. The operand regions read back what was written.
- R5: The length resets to 1 and accepts only values 1..MAX_WORDS. The ebits value resets to 0 and accepts only values 0..MAX_WORDS·WORD_W. Writes outside these ranges leave the stored value unchanged.
- R6: Operand words at index L or above are ignored by the arithmetic. Result words at index L or above read 0.
- R7: Status bit 0 (busy) is 1 from the clock after an accepted `start` until the job ends. Status bit 1 (done) is set at job end and cleared by the next accepted `start`. Both bits are 0 after reset.
- R8: While busy, host writes to every region are ignored and `start` is ignored.
- R9: Run time follows ebits: with the same length, a 2-bit exponent completes in under a third of the time taken by a full-length all-ones exponent.
- R10: The result region resets to 0, ignores host writes and changes only at job completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Region and word select |
| host_we | input | 1 | 1 writes host_wdata, 0 reads |
| host_wdata | input | WORD_W | Write data |
| host_rdata | output | WORD_W | Registered read data |
| start | input | 1 | One-cycle pulse that launches a job |

## Verification
The exponentiation chains up to a hundred dependent multiplications. A single wrong bit in the running product, a skipped square or a mis-stepped exponent index therefore corrupts the whole result word, and this shows up the first time the result is read after done. A stray control state, such as a busy flag that never drops or a job that ends early, shows at the status word within one poll. A late finish is caught by the cycle ratio between short and long exponents. Masking faults in the length handling show as non-zero upper result words, or as wrong values when stale high words were left in memory from an earlier wider job.

// File: rtl/mxp_pkg.sv
package mxp_pkg;
   typedef enum logic [2:0] {
      RG_MSG  = 3'd0,
      RG_EXP  = 3'd1,
      RG_MOD  = 3'd2,
      RG_RSQ  = 3'd3,
      RG_RES  = 3'd4,
      RG_CFG  = 3'd5,
      RG_STAT = 3'd6,
      RG_NONE = 3'd7
   } region_e;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_TOA, SQ_TOONE, SQ_SCAN, SQ_SQR, SQ_MUL, SQ_OUT
   } seq_e;
endpackage

// File: rtl/mxp_montmul.sv
module mxp_montmul #(
   parameter int MAXB = 128,
   parameter int CW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [CW-1:0]   nbits,
   input  logic [MAXB-1:0] x,
   input  logic [MAXB-1:0] y,
   input  logic [MAXB-1:0] m,
   output logic            done,
   output logic [MAXB-1:0] p
);
   localparam int SW = MAXB + 2;

   logic            run_q;
   logic [CW-1:0]   cnt_q;
   logic [SW-1:0]   s_q;
   logic [MAXB-1:0] xs_q;
   logic [SW-1:0]   y_w, m_w, t1, t2;

   assign y_w = {2'b00, y};
   assign m_w = {2'b00, m};
   assign t1  = s_q + (xs_q[0] ? y_w : '0);
   assign t2  = t1 + (t1[0] ? m_w : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         s_q   <= '0;
         xs_q  <= '0;
         done  <= 1'b0;
         p     <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            s_q   <= '0;
            xs_q  <= x;
            cnt_q <= nbits;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (cnt_q != '0) begin
               s_q   <= t2 >> 1;
               xs_q  <= xs_q >> 1;
               cnt_q <= cnt_q - 1'b1;
            end else begin
               run_q <= 1'b0;
               done  <= 1'b1;
               p     <= (s_q >= m_w) ? MAXB'(s_q - m_w) : MAXB'(s_q);
            end
         end
      end
   end

   AST_MM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && m[0]) |-> (s_q < {m_w[SW-2:0], 1'b0})); // R1
   AST_MM_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && m[0]) |-> ({2'b00, p} < m_w)); // R1
endmodule

// File: rtl/mxp_seq.sv
module mxp_seq
   import mxp_pkg::*;
#(
   parameter int MAXB = 128,
   parameter int CW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [MAXB-1:0] a_i,
   input  logic [MAXB-1:0] e_i,
   input  logic [MAXB-1:0] rr_i,
   input  logic [CW-1:0]   ebits_i,
   input  logic            mm_done,
   input  logic [MAXB-1:0] mm_p,
   output logic            mm_go,
   output logic [MAXB-1:0] mm_x,
   output logic [MAXB-1:0] mm_y,
   output logic            z_we,
   output logic            busy,
   output logic            done
);
   localparam logic [MAXB-1:0] ONE = MAXB'(1);

   seq_e            st;
   logic [MAXB-1:0] am_q, zm_q, e_sh;
   logic [CW-1:0]   bi_q;
   logic            seen_q, bit_q, cur_bit;

   assign e_sh    = e_i >> (bi_q - 1'b1);
   assign cur_bit = e_sh[0];
   assign busy    = (st != SQ_IDLE);
   assign z_we    = (st == SQ_OUT) && mm_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_IDLE;  am_q <= '0;  zm_q <= '0;  bi_q <= '0;
         seen_q <= 1'b0; bit_q <= 1'b0; done <= 1'b0;
         mm_go <= 1'b0;  mm_x <= '0;  mm_y <= '0;
      end else begin
         mm_go <= 1'b0;
         case (st)
            SQ_IDLE: if (start) begin
               done <= 1'b0; mm_go <= 1'b1; mm_x <= a_i; mm_y <= rr_i; st <= SQ_TOA;
            end
            SQ_TOA: if (mm_done) begin
               am_q <= mm_p; mm_go <= 1'b1; mm_x <= ONE; mm_y <= rr_i; st <= SQ_TOONE;
            end
            SQ_TOONE: if (mm_done) begin
               zm_q <= mm_p; bi_q <= ebits_i; seen_q <= 1'b0; st <= SQ_SCAN;
            end
            SQ_SCAN: if (bi_q == '0) begin
               mm_go <= 1'b1; mm_x <= zm_q; mm_y <= ONE; st <= SQ_OUT;
            end else begin
               bi_q <= bi_q - 1'b1;
               if (!seen_q) begin
                  if (cur_bit) begin
                     zm_q <= am_q; seen_q <= 1'b1;
                  end
               end else begin
                  bit_q <= cur_bit; mm_go <= 1'b1; mm_x <= zm_q; mm_y <= zm_q; st <= SQ_SQR;
               end
            end
            SQ_SQR: if (mm_done) begin
               zm_q <= mm_p;
               if (bit_q) begin
                  mm_go <= 1'b1; mm_x <= mm_p; mm_y <= am_q; st <= SQ_MUL;
               end else st <= SQ_SCAN;
            end
            SQ_MUL: if (mm_done) begin
               zm_q <= mm_p; st <= SQ_SCAN;
            end
            SQ_OUT: if (mm_done) begin
               done <= 1'b1; st <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R7
   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done); // R7
   AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      z_we |=> (done && !busy)); // R10
endmodule

// File: rtl/mxp_regs.sv
module mxp_regs
   import mxp_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MAX_WORDS = 4,
   parameter int IDX_W     = 2,
   parameter int ADDR_W    = 5,
   parameter int MAXB      = 128,
   parameter int CW        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_we,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic              z_we,
   input  logic [MAXB-1:0]   z_in,
   output logic [MAXB-1:0]   a_o,
   output logic [MAXB-1:0]   e_o,
   output logic [MAXB-1:0]   m_o,
   output logic [MAXB-1:0]   rr_o,
   output logic [CW-1:0]     ebits_o,
   output logic [CW-1:0]     nbits_o
);
   localparam int LW = $clog2(MAX_WORDS + 1);
   localparam int XW = WORD_W + 32;

   region_e           rg;
   logic [IDX_W-1:0]  idx;
   logic              wr_ok;
   logic [XW-1:0]     wd_x;
   logic [WORD_W-1:0] a_w [MAX_WORDS];
   logic [WORD_W-1:0] e_w [MAX_WORDS];
   logic [WORD_W-1:0] m_w [MAX_WORDS];
   logic [WORD_W-1:0] r_w [MAX_WORDS];
   logic [WORD_W-1:0] z_w [MAX_WORDS];
   logic [MAXB-1:0]   a_f, m_f, r_f, mask;
   logic [LW-1:0]     len_q;
   logic [CW-1:0]     eb_q;

   assign rg    = region_e'(host_addr[ADDR_W-1 -: 3]);
   assign idx   = host_addr[IDX_W-1:0];
   assign wr_ok = host_we && !busy;
   assign wd_x  = {32'b0, host_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_WORDS; i++) begin
            a_w[i] <= '0; e_w[i] <= '0; m_w[i] <= '0; r_w[i] <= '0; z_w[i] <= '0;
         end
         len_q <= LW'(1);
         eb_q  <= '0;
      end else begin
         if (z_we)
            for (int i = 0; i < MAX_WORDS; i++) z_w[i] <= z_in[i*WORD_W +: WORD_W];
         if (wr_ok) begin
            case (rg)
               RG_MSG: a_w[idx] <= host_wdata;
               RG_EXP: e_w[idx] <= host_wdata;
               RG_MOD: m_w[idx] <= host_wdata;
               RG_RSQ: r_w[idx] <= host_wdata;
               RG_CFG: begin
                  if (idx == IDX_W'(0)) begin
                     if (wd_x >= XW'(1) && wd_x <= XW'(MAX_WORDS)) len_q <= LW'(host_wdata);
                  end else if (idx == IDX_W'(1)) begin
                     if (wd_x <= XW'(MAXB)) eb_q <= CW'(host_wdata);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_rdata <= '0;
      else begin
         case (rg)
            RG_MSG:  host_rdata <= a_w[idx];
            RG_EXP:  host_rdata <= e_w[idx];
            RG_MOD:  host_rdata <= m_w[idx];
            RG_RSQ:  host_rdata <= r_w[idx];
            RG_RES:  host_rdata <= z_w[idx];
            RG_CFG:  host_rdata <= (idx == IDX_W'(0)) ? WORD_W'(len_q) :
                                   (idx == IDX_W'(1)) ? WORD_W'(eb_q) : '0;
            RG_STAT: host_rdata <= WORD_W'({done, busy});
            default: host_rdata <= '0;
         endcase
      end
   end

   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_pack
      assign a_f[w*WORD_W +: WORD_W] = a_w[w];
      assign e_o[w*WORD_W +: WORD_W] = e_w[w];
      assign m_f[w*WORD_W +: WORD_W] = m_w[w];
      assign r_f[w*WORD_W +: WORD_W] = r_w[w];
   end

   assign nbits_o = CW'(len_q * WORD_W);
   assign mask    = ~({MAXB{1'b1}} << nbits_o);
   assign a_o     = a_f & mask;
   assign m_o     = m_f & mask;
   assign rr_o    = r_f & mask;
   assign ebits_o = eb_q;

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(a_f) && $stable(e_o) && $stable(m_f) && $stable(r_f))); // R8
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(len_q) && $stable(eb_q))); // R8
   AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && rg == RG_CFG && idx == IDX_W'(0) && host_wdata == '0) |=> $stable(len_q)); // R5
endmodule

// File: rtl/mxp_engine.sv
module mxp_engine #(
   parameter int WORD_W    = 32,
   parameter int MAX_WORDS = 4,
   parameter int ADDR_W    = $clog2(MAX_WORDS) + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_we,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              start
);
   localparam int IDX_W = $clog2(MAX_WORDS);
   localparam int MAXB  = MAX_WORDS * WORD_W;
   localparam int CW    = $clog2(MAXB + 1);

   if (WORD_W != 16 && WORD_W != 32 && WORD_W != 64) begin : g_bad_word
      $error("mxp_engine: WORD_W must be 16, 32 or 64");
   end
   if (MAX_WORDS < 2 || (MAX_WORDS & (MAX_WORDS - 1)) != 0) begin : g_bad_depth
      $error("mxp_engine: MAX_WORDS must be a power of two, at least 2");
   end
   if (ADDR_W != IDX_W + 3) begin : g_bad_addr
      $error("mxp_engine: ADDR_W must equal log2(MAX_WORDS)+3");
   end

   logic            busy, done, z_we, mm_go, mm_done;
   logic [MAXB-1:0] a_v, e_v, m_v, rr_v, mm_x, mm_y, mm_p;
   logic [CW-1:0]   ebits, nbits;

   mxp_regs #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W),
              .ADDR_W(ADDR_W), .MAXB(MAXB), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .done(done),
      .z_we(z_we), .z_in(mm_p), .a_o(a_v), .e_o(e_v), .m_o(m_v), .rr_o(rr_v),
      .ebits_o(ebits), .nbits_o(nbits));

   mxp_seq #(.MAXB(MAXB), .CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .a_i(a_v), .e_i(e_v), .rr_i(rr_v),
      .ebits_i(ebits), .mm_done(mm_done), .mm_p(mm_p), .mm_go(mm_go),
      .mm_x(mm_x), .mm_y(mm_y), .z_we(z_we), .busy(busy), .done(done));

   mxp_montmul #(.MAXB(MAXB), .CW(CW)) u_mm (
      .clk(clk), .rst_n(rst_n), .go(mm_go), .nbits(nbits), .x(mm_x), .y(mm_y),
      .m(m_v), .done(mm_done), .p(mm_p));
endmodule

// File: tb/test_mxp_engine.sv
`timescale 1ns/1ps
module test_mxp_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0;
   logic        host_we = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        start = 1'b0;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mxp_engine #(.WORD_W(16), .MAX_WORDS(2)) i_mxp_engine (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start));

   function automatic logic [3:0] ad(int rg, int ix);
      return 4'(rg * 2 + ix);
   endfunction

   function automatic longint unsigned mexp(longint unsigned a, longint unsigned e,
                                            int eb, longint unsigned m);
      longint unsigned r = 1 % m;
      for (int i = eb - 1; i >= 0; i--) begin
         r = (r * r) % m;
         if (e[i]) r = (r * a) % m;
      end
      return r;
   endfunction

   function automatic longint unsigned rsq(longint unsigned m, int len);
      longint unsigned r = 1 % m;
      for (int i = 0; i < 2 * len * 16; i++) r = (r * 2) % m;
      return r;
   endfunction

   task automatic check(string req, longint unsigned got, longint unsigned exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [15:0] d);
      host_addr = a; host_we = 1'b0;
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic wr2(int rg, longint unsigned v);
      wr(ad(rg, 0), v[15:0]);
      wr(ad(rg, 1), v[31:16]);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      logic [15:0] s;
      cyc = 0;
      do begin
         rd(ad(6, 0), s);
         cyc++;
      end while (!s[1] && cyc < 30000);
   endtask

   task automatic read_z(output longint unsigned z);
      logic [15:0] lo, hi;
      rd(ad(4, 0), lo);
      rd(ad(4, 1), hi);
      z = {32'b0, hi, lo};
   endtask

   task automatic load(int len, longint unsigned a, longint unsigned e, int eb,
                       longint unsigned m);
      longint unsigned msk = (len == 1) ? 64'hFFFF : 64'hFFFF_FFFF;
      wr(ad(5, 0), 16'(len));
      wr(ad(5, 1), 16'(eb));
      wr2(0, a);
      wr2(1, e);
      wr2(2, m);
      wr2(3, rsq(m & msk, len) | (m & ~msk));
   endtask

   task automatic do_op(int len, longint unsigned a, longint unsigned e, int eb,
                        longint unsigned m, output longint unsigned z, output int cyc);
      load(len, a, e, eb, m);
      pulse_start();
      wait_done(cyc);
      read_z(z);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      longint unsigned z;
      longint unsigned mods [4] = '{64'hFFF1, 64'h8001, 64'h00C5, 64'h0003};
      longint unsigned exps [4] = '{64'h3, 64'h11, 64'hBEEF, 64'hFFFF};
      int ebs [4] = '{2, 5, 16, 16};
      int cyc, cyc_s, cyc_l;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 R10 R5: reset state
      rd(ad(6, 0), d); check("R7 reset status", d, 0);
      rd(ad(4, 0), d); check("R10 reset result", d, 0);
      rd(ad(5, 0), d); check("R5 reset length", d, 1);
      rd(ad(5, 1), d); check("R5 reset ebits", d, 0);

      // R5: out-of-range configuration writes
      wr(ad(5, 0), 16'd0); rd(ad(5, 0), d); check("R5 length 0 rejected", d, 1);
      wr(ad(5, 0), 16'd3); rd(ad(5, 0), d); check("R5 length 3 rejected", d, 1);
      wr(ad(5, 0), 16'd2); rd(ad(5, 0), d); check("R5 length 2 accepted", d, 2);
      wr(ad(5, 1), 16'd33); rd(ad(5, 1), d); check("R5 ebits 33 rejected", d, 0);
      wr(ad(5, 1), 16'd32); rd(ad(5, 1), d); check("R5 ebits 32 accepted", d, 32);

      // R4: operand read-back and word order
      wr(ad(2, 1), 16'hA5C3); rd(ad(2, 1), d); check("R4 modulus word1 readback", d, 16'hA5C3);
      wr(ad(0, 0), 16'h1357); rd(ad(0, 0), d); check("R4 message word0 readback", d, 16'h1357);
      // R10: result region ignores host writes
      wr(ad(4, 0), 16'hDEAD); rd(ad(4, 0), d); check("R10 result write ignored", d, 0);

      // R1 R6: sweep over one-word moduli with junk in the upper words
      foreach (mods[mi]) begin
         for (int ai = 0; ai < 2; ai++) begin
            foreach (exps[ei]) begin
               longint unsigned m = mods[mi];
               longint unsigned a = (ai == 0) ? (64'h1234 % m) : (m - 1);
               do_op(1, a | 64'h5A5A_0000, exps[ei] | 64'h7000_0000, ebs[ei],
                     m | 64'hC3C3_0000, z, cyc);
               check("R1 R6 one-word result", z, mexp(a, exps[ei], ebs[ei], m));
            end
         end
      end

      // R1: two-word moduli, full-length exponents
      do_op(2, 64'h1234_5678, 64'hFFFF_FFFF, 32, 64'hFFFF_FFFB, z, cyc_l);
      check("R1 two-word all-ones exponent", z, mexp(64'h1234_5678, 64'hFFFF_FFFF, 32, 64'hFFFF_FFFB));
      do_op(2, 64'h8000_0000, 64'hA5A5_0F0F, 32, 64'h8000_0001, z, cyc);
      check("R1 two-word mixed exponent", z, mexp(64'h8000_0000, 64'hA5A5_0F0F, 32, 64'h8000_0001));
      do_op(2, 64'hCAFE_F00D, 64'h0001_0001, 17, 64'hF123_4567, z, cyc);
      check("R1 two-word exponent 65537", z, mexp(64'hCAFE_F00D, 64'h0001_0001, 17, 64'hF123_4567));

      // R2 R9: bits above ebits ignored; short exponent runs faster
      do_op(2, 64'h1234_5678, 64'hFFFF_FFF3, 2, 64'hFFFF_FFFB, z, cyc_s);
      check("R2 high exponent bits ignored", z, mexp(64'h1234_5678, 64'h3, 2, 64'hFFFF_FFFB));
      check("R9 short exponent under a third", (cyc_s * 3 < cyc_l) ? 1 : 0, 1);

      // R3: zero exponent forms
      do_op(2, 64'h0BAD_BEEF, 64'hFFFF_FFFF, 0, 64'hFFFF_FFFB, z, cyc);
      check("R3 ebits 0 gives one", z, 1);
      do_op(1, 64'h0042, 64'h0, 8, 64'h00C5, z, cyc);
      check("R3 zero exponent bits give one", z, 1);
      do_op(1, 64'h0, 64'h5, 3, 64'h0001, z, cyc);
      check("R3 modulus one gives zero", z, 0);

      // R7 R8: status, writes and start ignored while busy
      load(1, 64'h1234, 64'hBEEF, 16, 64'hFFF1);
      pulse_start();
      rd(ad(6, 0), d); check("R7 busy set and done cleared", d, 1);
      wr(ad(0, 0), 16'h0BAD);
      wr(ad(5, 0), 16'd2);
      wr(ad(5, 1), 16'd3);
      pulse_start();
      wait_done(cyc);
      rd(ad(6, 0), d); check("R7 done after finish", d, 2);
      read_z(z);
      check("R8 result unaffected by busy writes", z, mexp(64'h1234, 64'hBEEF, 16, 64'hFFF1));
      rd(ad(0, 0), d); check("R8 message write ignored", d, 16'h1234);
      rd(ad(5, 0), d); check("R8 length write ignored", d, 1);
      rd(ad(5, 1), d); check("R8 ebits write ignored", d, 16);
      check("R6 upper result word zero", z >> 16, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule